// File: doc/BRIEF.md
# Dual-Mode Split Read Port

This block is the read half of a frame-buffer FIFO. It holds two 16-bit storage lanes, a read address pointer for each lane, and a registered output word for each lane. A single mode pin sets the shape of the output. With the pin low, the block is one 32-bit read port and channel 0's controls run it. With the pin high, it is two separate 16-bit read ports, A and B, and each has its own clock and controls. A plain write port loads the lanes so the block can be tested.

On every rising edge of a lane's read clock, an active read enable copies the word at the pointer into the lane's output register and moves the pointer on. Output enable only gates what leaves the pins. Read reset returns the pointer to zero. Each channel also gives a loop-out clock, which is its read clock either passed through or inverted, and a registered echo of its read enable.

The data flow is push-only: a word appears one read-clock edge after it is requested, and there is no ready signal. The consumer paces reads with read enable, so back-pressure means holding read enable low. The mode pin may change only while both read resets are held high.

Top module: `rdp_split_read_port`

## Requirements
- R1: While `rst_n` is low, both pointers, both output registers and both echo flops clear at once. `dout` reads zero and both echoes read 0.
- R2: With `mode16`=0, channel 0's controls run both lanes on `rclk0` with one shared pointer. `dout[15:0]` is lane A's word and `dout[31:16]` is lane B's word from the same address. Every channel-1 input (`rclk1`, `ren1`, `oe1`, `rrst1`, `loinv1`) has no effect.
- R3: With `mode16`=1, channel 0 runs lane A on `rclk0` and channel 1 runs lane B on `rclk1`. Each lane has its own pointer, and activity on one channel leaves the other lane's output unchanged.
- R4: When read enable is 1 and read reset is 0 at a rising edge, the lane's output register takes the word at the pointer and the pointer advances by one. The word is visible one edge after the request.
- R5: The pointer advances on an enabled read whatever the output enable level is.
- R6: When output enable is 0, the lane's half of `dout` reads zero straight away, with no clock edge needed. When it is 1, that half shows the output register.
- R7: When read reset is 1 at an edge, the pointer becomes 0 even if read enable is also 1. The output register holds its value.
- R8: After reading address DEPTH-1, the pointer wraps to 0.
- R9: Each echo output equals that channel's read enable as sampled at the previous rising edge of the read clock. Each loop-out clock equals the read clock XOR the inversion input (0 = pass through, 1 = inverted). In 32-bit mode both loop-out clocks and both echoes follow channel 0.
- R10: With read enable 0 and read reset 0, the pointer and the output register hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of pointers, output registers and echoes |
| mode16 | input | 1 | 0 = one 32-bit bus, 1 = two 16-bit buses |
| wr_clk | input | 1 | Test write clock |
| wr_en | input | 1 | Test write strobe |
| wr_addr | input | $clog2(DEPTH) | Test write address |
| wr_data | input | 32 | Test write data; bits 15:0 go to lane A, bits 31:16 to lane B |
| wr_lane | input | 2 | Per-lane write enable; bit 0 selects lane A, bit 1 selects lane B |
| rclk0 | input | 1 | Channel 0 read clock |
| ren0 | input | 1 | Channel 0 read enable |
| oe0 | input | 1 | Channel 0 output enable |
| rrst0 | input | 1 | Channel 0 read reset |
| loinv0 | input | 1 | Channel 0 loop-out clock inversion |
| rclk1 | input | 1 | Channel 1 read clock |
| ren1 | input | 1 | Channel 1 read enable |
| oe1 | input | 1 | Channel 1 output enable |
| rrst1 | input | 1 | Channel 1 read reset |
| loinv1 | input | 1 | Channel 1 loop-out clock inversion |
| dout | output | 32 | Read data: lane A in bits 15:0, lane B in bits 31:16 |
| lo_clk0 | output | 1 | Channel 0 loop-out clock |
| ren_echo0 | output | 1 | Channel 0 registered read-enable echo |
| lo_clk1 | output | 1 | Channel 1 loop-out clock |
| ren_echo1 | output | 1 | Channel 1 registered read-enable echo |

## Verification
The pointers cannot be seen directly, so the memory is filled with distinct random words. A pointer that skips, sticks or wraps at the wrong place then shows up at the very next enabled read, one read-clock edge later, as a word that does not match the model. A lane wired to the wrong clock or controls in either mode shows up on that read too. A lapse in output gating or in the echo register shows on the same edge or straight away. The bench also runs both 16-bit channels at once on clocks of different periods, and reads long enough to cross the wrap point in each mode.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
  localparam int LANE_W  = 16;
  localparam int N_LANES = 2;
  localparam int BUS_W   = LANE_W * N_LANES;

  typedef struct packed {
    logic ren;
    logic oe;
    logic rrst;
    logic inv;
  } lane_ctl_t;
endpackage

// File: rtl/rdp_store.sv
module rdp_store #(
  parameter int DEPTH = 256,
  parameter int W     = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          wr_clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (wr_en && ({1'b0, wr_addr} < (AW+1)'(DEPTH)))
      mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/rdp_route.sv
module rdp_route
  import rdp_pkg::*;
#(
  parameter int NL = N_LANES
) (
  input  logic                 mode16,
  input  logic [NL-1:0]        ch_clk,
  input  lane_ctl_t [NL-1:0]   ch_ctl,
  output logic [NL-1:0]        lane_clk,
  output lane_ctl_t [NL-1:0]   lane_ctl
);
  for (genvar i = 0; i < NL; i++) begin : g_route
    if (i == 0) begin : g_master
      assign lane_clk[i] = ch_clk[0];
      assign lane_ctl[i] = ch_ctl[0];
    end else begin : g_follow
      // wide mode: every lane follows channel 0
      assign lane_clk[i] = mode16 ? ch_clk[i] : ch_clk[0];
      assign lane_ctl[i] = mode16 ? ch_ctl[i] : ch_ctl[0];
    end
  end
endmodule

// File: rtl/rdp_lane.sv
module rdp_lane
  import rdp_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int W     = LANE_W,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  lane_ctl_t     ctl,
  output logic [AW-1:0] rd_addr,
  input  logic [W-1:0]  rd_data,
  output logic [W-1:0]  dout,
  output logic          lo_clk,
  output logic          echo
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr;
  logic [W-1:0]  data_q;
  logic          echo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr    <= '0;
      data_q <= '0;
      echo_q <= 1'b0;
    end else begin
      echo_q <= ctl.ren;
      if (ctl.rrst) begin
        ptr <= '0;
      end else if (ctl.ren) begin
        data_q <= rd_data;
        ptr    <= (ptr == LAST) ? '0 : ptr + 1'b1;
      end
    end
  end

  assign rd_addr = ptr;
  assign dout    = ctl.oe ? data_q : '0;
  assign lo_clk  = clk ^ ctl.inv;
  assign echo    = echo_q;

  // R4
  ptr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.ren && !ctl.rrst && ptr != LAST) |=> ptr == $past(ptr) + 1'b1);

  // R4
  data_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.ren && !ctl.rrst) |=> data_q == $past(rd_data));

  // R8
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.ren && !ctl.rrst && ptr == LAST) |=> ptr == '0);

  // R7
  rrst_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.rrst |=> (ptr == '0) && $stable(data_q));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.ren && !ctl.rrst) |=> $stable(ptr) && $stable(data_q));

  // R9
  echo_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> echo == $past(ctl.ren));
endmodule

// File: rtl/rdp_split_read_port.sv
module rdp_split_read_port
  import rdp_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             rst_n,
  input  logic             mode16,
  input  logic             wr_clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [BUS_W-1:0] wr_data,
  input  logic [N_LANES-1:0] wr_lane,
  input  logic             rclk0,
  input  logic             ren0,
  input  logic             oe0,
  input  logic             rrst0,
  input  logic             loinv0,
  input  logic             rclk1,
  input  logic             ren1,
  input  logic             oe1,
  input  logic             rrst1,
  input  logic             loinv1,
  output logic [BUS_W-1:0] dout,
  output logic             lo_clk0,
  output logic             ren_echo0,
  output logic             lo_clk1,
  output logic             ren_echo1
);
  logic      [N_LANES-1:0] ch_clk;
  lane_ctl_t [N_LANES-1:0] ch_ctl;
  logic      [N_LANES-1:0] lane_clk;
  lane_ctl_t [N_LANES-1:0] lane_ctl;
  logic      [N_LANES-1:0] lane_lo;
  logic      [N_LANES-1:0] lane_echo;

  assign ch_clk    = {rclk1, rclk0};
  assign ch_ctl[0] = {ren0, oe0, rrst0, loinv0};
  assign ch_ctl[1] = {ren1, oe1, rrst1, loinv1};

  rdp_route #(.NL(N_LANES)) route_i (
    .mode16   (mode16),
    .ch_clk   (ch_clk),
    .ch_ctl   (ch_ctl),
    .lane_clk (lane_clk),
    .lane_ctl (lane_ctl)
  );

  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    logic [AW-1:0]     addr;
    logic [LANE_W-1:0] word;

    rdp_store #(.DEPTH(DEPTH), .W(LANE_W)) store_i (
      .wr_clk  (wr_clk),
      .wr_en   (wr_en & wr_lane[i]),
      .wr_addr (wr_addr),
      .wr_data (wr_data[i*LANE_W +: LANE_W]),
      .rd_addr (addr),
      .rd_data (word)
    );

    rdp_lane #(.DEPTH(DEPTH), .W(LANE_W)) lane_i (
      .clk     (lane_clk[i]),
      .rst_n   (rst_n),
      .ctl     (lane_ctl[i]),
      .rd_addr (addr),
      .rd_data (word),
      .dout    (dout[i*LANE_W +: LANE_W]),
      .lo_clk  (lane_lo[i]),
      .echo    (lane_echo[i])
    );
  end

  assign lo_clk0   = lane_lo[0];
  assign lo_clk1   = lane_lo[1];
  assign ren_echo0 = lane_echo[0];
  assign ren_echo1 = lane_echo[1];

  // R1
  reset_quiet_chk: assert property (@(posedge rclk0)
    !rst_n |-> (ren_echo0 == 1'b0) && (ren_echo1 == 1'b0));
endmodule

// File: tb/rdp_split_read_port_tb_top.sv
module rdp_split_read_port_tb_top;
  localparam int DEPTH = 12;
  localparam int AW    = $clog2(DEPTH);

  logic rst_n = 0, mode16 = 0;
  logic wclk = 0, rclk0 = 0, rclk1 = 0;
  logic wr_en = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  wr_lane = 2'b11;
  logic ren0 = 0, oe0 = 0, rrst0 = 0, loinv0 = 0;
  logic ren1 = 0, oe1 = 0, rrst1 = 0, loinv1 = 0;
  logic [31:0] dout;
  logic lo_clk0, ren_echo0, lo_clk1, ren_echo1;

  always #10 rclk0 = ~rclk0;   // 50 MHz
  always #10 wclk  = ~wclk;
  always #13 rclk1 = ~rclk1;

  rdp_split_read_port #(.DEPTH(DEPTH)) dut_i (
    .rst_n(rst_n), .mode16(mode16), .wr_clk(wclk), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_lane(wr_lane),
    .rclk0(rclk0), .ren0(ren0), .oe0(oe0), .rrst0(rrst0), .loinv0(loinv0),
    .rclk1(rclk1), .ren1(ren1), .oe1(oe1), .rrst1(rrst1), .loinv1(loinv1),
    .dout(dout), .lo_clk0(lo_clk0), .ren_echo0(ren_echo0),
    .lo_clk1(lo_clk1), .ren_echo1(ren_echo1)
  );

  int errors = 0, checks = 0;
  bit done = 0;
  logic [15:0] mA [DEPTH];
  logic [15:0] mB [DEPTH];
  int ptr [2];
  logic [15:0] xd [2];

  function automatic int nxt(int p);
    return (p == DEPTH - 1) ? 0 : p + 1;
  endfunction

  function automatic logic [15:0] word_at(int ch, int p);
    return (ch == 1) ? mB[p] : mA[p];
  endfunction

  function automatic bit pick(int pct);
    return ($urandom % 100) < pct;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic drive(int ch, bit ren, bit oe, bit rrst, bit inv);
    if (ch == 0) begin ren0 = ren; oe0 = oe; rrst0 = rrst; loinv0 = inv; end
    else         begin ren1 = ren; oe1 = oe; rrst1 = rrst; loinv1 = inv; end
  endtask

  // 16-bit mode step; caller is at a falling edge of this channel's clock
  task automatic step16(int ch, bit ren, bit oe, bit rrst, bit inv, string req);
    logic [15:0] half;
    drive(ch, ren, oe, rrst, inv);
    if (ch == 0) @(posedge rclk0); else @(posedge rclk1);
    if (rrst) ptr[ch] = 0;
    else if (ren) begin xd[ch] = word_at(ch, ptr[ch]); ptr[ch] = nxt(ptr[ch]); end
    if (ch == 0) @(negedge rclk0); else @(negedge rclk1);
    half = (ch == 0) ? dout[15:0] : dout[31:16];
    check(req, {16'h0, half}, {16'h0, oe ? xd[ch] : 16'h0});
    check("R9 echo", {31'h0, (ch == 0) ? ren_echo0 : ren_echo1}, {31'h0, ren});
    check("R9 loop clk", {31'h0, (ch == 0) ? lo_clk0 : lo_clk1}, {31'h0, inv});
  endtask

  // 32-bit mode step; caller is at a falling edge of rclk0
  task automatic step32(bit ren, bit oe, bit rrst, bit inv, string req);
    drive(0, ren, oe, rrst, inv);
    drive(1, pick(50), pick(50), pick(50), pick(50));  // R2: ignored
    @(posedge rclk0);
    if (rrst) ptr[0] = 0;
    else if (ren) begin
      xd[0] = mA[ptr[0]]; xd[1] = mB[ptr[0]]; ptr[0] = nxt(ptr[0]);
    end
    @(negedge rclk0);
    check(req, dout, oe ? {xd[1], xd[0]} : 32'h0);
    check("R9 echo", {30'h0, ren_echo1, ren_echo0}, {30'h0, ren, ren});
    check("R9 loop clk", {30'h0, lo_clk1, lo_clk0}, {30'h0, inv, inv});
  endtask

  task automatic set_mode(bit m);
    @(negedge rclk0); rrst0 = 1; ren0 = 0;
    @(negedge rclk1); rrst1 = 1; ren1 = 0;
    repeat (3) @(negedge rclk0);
    repeat (3) @(negedge rclk1);
    @(negedge rclk0); mode16 = m;
    repeat (3) @(negedge rclk0);
    repeat (3) @(negedge rclk1);
    ptr[0] = 0; ptr[1] = 0;
    @(negedge rclk0);
  endtask

  initial begin
    repeat (100000) @(posedge rclk0);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    ptr[0] = 0; ptr[1] = 0; xd[0] = '0; xd[1] = '0;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge wclk);
      wr_en = 1; wr_addr = AW'(i); wr_data = $urandom;
      mA[i] = wr_data[15:0]; mB[i] = wr_data[31:16];
    end
    @(negedge wclk); wr_en = 0;

    // R1: reset state with outputs enabled
    oe0 = 1; oe1 = 1; ren0 = 1;
    @(negedge rclk0);
    check("R1 dout", dout, 32'h0);
    check("R1 echo", {30'h0, ren_echo1, ren_echo0}, 32'h0);
    ren0 = 0;
    @(negedge rclk0); rst_n = 1;
    @(negedge rclk0);

    // 32-bit mode directed
    repeat (3) step32(1, 1, 0, 0, "R4 read");
    repeat (2) step32(1, 0, 0, 0, "R6 oe low");
    step32(1, 1, 0, 0, "R5 ptr moved while oe low");
    repeat (2) step32(0, 1, 0, 0, "R10 hold");
    step32(1, 1, 1, 0, "R7 rrst beats ren");
    step32(1, 1, 0, 1, "R7 read from zero");
    repeat (DEPTH + 2) step32(1, 1, 0, 1, "R8 wrap");
    for (int i = 0; i < 120; i++)
      step32(pick(70), pick(80), pick(8), pick(50), "R2 random wide");

    // 16-bit mode: channels on independent clocks
    set_mode(1);
    fork
      begin
        repeat (3) step16(0, 1, 1, 0, 0, "R3 lane A read");
        step16(0, 1, 0, 0, 1, "R6 lane A oe low");
        step16(0, 1, 1, 1, 0, "R7 lane A rrst");
        repeat (DEPTH + 1) step16(0, 1, 1, 0, 0, "R8 lane A wrap");
        for (int i = 0; i < 100; i++)
          step16(0, pick(65), pick(80), pick(8), pick(50), "R3 lane A random");
      end
      begin
        @(negedge rclk1);
        repeat (5) step16(1, 0, 1, 0, 0, "R3 lane B idle");
        repeat (2) step16(1, 1, 0, 0, 1, "R5 lane B oe low");
        step16(1, 0, 1, 0, 0, "R5 lane B shows moved ptr");
        step16(1, 1, 1, 0, 0, "R4 lane B read");
        repeat (DEPTH + 1) step16(1, 1, 1, 0, 1, "R8 lane B wrap");
        for (int i = 0; i < 100; i++)
          step16(1, pick(65), pick(80), pick(8), pick(50), "R3 lane B random");
      end
    join

    // back to 32-bit mode
    set_mode(0);
    for (int i = 0; i < 40; i++)
      step32(pick(70), pick(80), pick(8), pick(50), "R2 random after switch");

    // R1: asynchronous clear mid-run
    oe0 = 1; ren0 = 1; rrst0 = 0;
    #3 rst_n = 0;
    #1 check("R1 async clear dout", dout, 32'h0);
    @(negedge rclk0);
    check("R1 async clear echo", {30'h0, ren_echo1, ren_echo0}, 32'h0);
    rst_n = 1; ren0 = 0;
    ptr[0] = 0; xd[0] = '0; xd[1] = '0;
    step32(1, 1, 0, 0, "R1 first read after clear");
    step32(1, 1, 0, 0, "R4 second read after clear");
    finish_run();
  end
endmodule